// File: doc/BRIEF.md
# Idle-Locked Self-Synchronizing Stream Descrambler

This block recovers plaintext from a scrambled 100Base-X style bit stream. The far end whitens its data with an 11-bit linear feedback shift register. The receiver has no shared seed, so it rebuilds the far end's register from the line itself. Between packets the plaintext is all ones, which means every received bit during that gap is the inverse of the far end's key bit. While hunting, the block shifts those inverted bits straight into its own register. It declares lock once its predictions have matched the line for a full run.

The input arrives in a variable-rate form: each cycle carries zero, one or two new bits. The output keeps the same form, one cycle later, and adds a lock flag. Once locked, the register runs freely. A watchdog counts the bits seen since the last full idle run and drops back to hunting when that count reaches a programmable limit. The default limit is 36000 bits (4500 bytes); a larger value supports longer frames.

Top module: `idle_lock_descrambler`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `out_valid`, `out_data` and `out_locked` to zero.
- R2: `in_valid` is decoded as follows. 0 carries no bit. 1 carries one bit, in `in_data[1]`. 2 or 3 carries two bits; `in_data[0]` is the older bit and is processed first, then `in_data[1]`.
- R3: `out_valid` equals the `in_valid` of the previous cycle. An output position that carries no bit is 0: both positions when the value is 0, and `out_data[0]` when the value is 1.
- R4: Each output bit is the received bit XOR the key bit `s[10]^s[8]` of the 11-bit register `s` (polynomial x^11+x^9+1). After each bit, `s` shifts left and takes the new bit at `s[0]`. While locked, that new bit is the key bit. Once locked, the output equals the far end's plaintext.
- R5: While hunting, the new bit shifted into `s` is the inverted received bit. `out_locked` stays 0 until LOCK_RUN (default 29) consecutive bits have descrambled to 1, so it is still 0 after LOCK_RUN-1 idle bits.
- R6: Starting from any register state, an unbroken idle gap of LOCK_RUN+11 bits sets `out_locked`. This holds with one or two bits per cycle.
- R7: While locked, each bit that does not complete a run of LOCK_RUN ones advances a bit counter. The bit that takes the counter to UNLOCK_BITS (default 36000) returns the block to hunting, and `out_locked` goes to 0.
- R8: A run of LOCK_RUN consecutive ones clears the bit counter, even on the bit that would otherwise expire it. A run of LOCK_RUN-1 ones does not clear it.
- R9: A cycle with `in_valid` = 0 leaves the register, the run and the counter unchanged. The bits on `in_data` in that cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 2 | Count code for the received bits (R2) |
| in_data | input | 2 | Scrambled bits; bit 1 is the newest |
| out_valid | output | 2 | `in_valid` delayed by one cycle |
| out_data | output | 2 | Descrambled bits; positions with no bit are 0 |
| out_locked | output | 1 | High while the register tracks the far end |

## Verification
On every cycle, the inline assertions check four things:
- the output valid code follows the input code, and positions with no bit stay at zero;
- an idle-input cycle leaves the register state untouched;
- the watchdog counter stays in range and is zero while hunting;
- lock falls only after the counter has come within two bits of its limit.

Only the bench scenarios can show the rest:
- that recovered data equals the far end's plaintext;
- that lock arrives within the stated idle window but never before a full run;
- that exactly LOCK_RUN ones refresh the watchdog at its last bit while one fewer does not;
- that lock can be acquired in the middle of a two-bit cycle.

// File: rtl/idl_pkg.sv
// Shared constants, types and the key function for the idle-locked descrambler.
package idl_pkg;

    localparam int LFSR_W = 11;

    typedef logic [LFSR_W-1:0] lfsr_t;

    typedef enum logic {
        ST_HUNT   = 1'b0,
        ST_LOCKED = 1'b1
    } mode_e;

    // Key bit of the x^11 + x^9 + 1 register.
    function automatic logic key_bit(input lfsr_t s);
        return s[10] ^ s[8];
    endfunction

endpackage

// File: rtl/idl_bit_step.sv
// One-bit descrambler step (combinational).
// Takes the register state, the run length, the watchdog counter and the mode,
// and returns the state after one received bit plus the descrambled bit.
// Assumes: when en is low, everything passes through and pbit_o is 0.
module idl_bit_step
    import idl_pkg::*;
#(
    parameter int LOCK_RUN    = 29,
    parameter int UNLOCK_BITS = 36000,
    parameter int RUN_W       = 5,
    parameter int TMR_W       = 16
) (
    input  logic             en,
    input  logic             cbit,
    input  lfsr_t            lfsr_i,
    input  logic [RUN_W-1:0] run_i,
    input  logic [TMR_W-1:0] tmr_i,
    input  mode_e            mode_i,
    output lfsr_t            lfsr_o,
    output logic [RUN_W-1:0] run_o,
    output logic [TMR_W-1:0] tmr_o,
    output mode_e            mode_o,
    output logic             pbit_o
);

    localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(LOCK_RUN);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(UNLOCK_BITS - 1);

    logic             key;
    logic             plain;
    logic [RUN_W-1:0] run_n;

    // Descramble the bit, advance the register, and update the lock/watchdog state.
    always_comb begin
        key    = key_bit(lfsr_i);
        plain  = cbit ^ key;
        run_n  = run_i;
        lfsr_o = lfsr_i;
        run_o  = run_i;
        tmr_o  = tmr_i;
        mode_o = mode_i;
        pbit_o = 1'b0;
        if (en) begin
            pbit_o = plain;
            lfsr_o = {lfsr_i[LFSR_W-2:0], (mode_i == ST_LOCKED) ? key : ~cbit};
            if (!plain)
                run_n = '0;
            else if (run_i != RUN_MAX)
                run_n = run_i + 1'b1;
            run_o = run_n;
            if (mode_i == ST_HUNT) begin
                tmr_o = '0;
                if (run_n == RUN_MAX)
                    mode_o = ST_LOCKED;
            end else if (run_n == RUN_MAX) begin
                tmr_o = '0;
            end else if (tmr_i == TMR_LAST) begin
                mode_o = ST_HUNT;
                tmr_o  = '0;
                run_o  = '0;
            end else begin
                tmr_o = tmr_i + 1'b1;
            end
        end
    end

endmodule

// File: rtl/idl_state_reg.sv
// State register for the descrambler: the register, the run, the watchdog and the mode.
// Assumes: synchronous active-low reset; the next state already accounts for every
// bit in the cycle.
module idl_state_reg
    import idl_pkg::*;
#(
    parameter int LOCK_RUN    = 29,
    parameter int UNLOCK_BITS = 36000,
    parameter int RUN_W       = 5,
    parameter int TMR_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       in_valid,
    input  lfsr_t            lfsr_d,
    input  logic [RUN_W-1:0] run_d,
    input  logic [TMR_W-1:0] tmr_d,
    input  mode_e            mode_d,
    output lfsr_t            lfsr_q,
    output logic [RUN_W-1:0] run_q,
    output logic [TMR_W-1:0] tmr_q,
    output mode_e            mode_q
);

    // Load the next state, or clear it while in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q <= '0;
            run_q  <= '0;
            tmr_q  <= '0;
            mode_q <= ST_HUNT;
        end else begin
            lfsr_q <= lfsr_d;
            run_q  <= run_d;
            tmr_q  <= tmr_d;
            mode_q <= mode_d;
        end
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid == 2'b00) |=> ($stable(lfsr_q) && $stable(run_q) && $stable(tmr_q) && $stable(mode_q))); // R9
    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q < TMR_W'(UNLOCK_BITS)); // R7
    AST_HUNT_TMR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == ST_HUNT) |-> (tmr_q == '0)); // R7
    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(LOCK_RUN)); // R5
    AST_UNLOCK_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_q == ST_LOCKED) |-> ($past(tmr_q) >= TMR_W'(UNLOCK_BITS - 2))); // R7

endmodule

// File: rtl/idl_out_reg.sv
// Output register: delays the valid code by one cycle and registers the descrambled bits.
// Assumes: the step stages already drive 0 on positions that carry no bit.
module idl_out_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] in_valid,
    input  logic [1:0] pbits,
    output logic [1:0] out_valid,
    output logic [1:0] out_data
);

    // Register the valid code and the bits for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 2'b00;
            out_data  <= 2'b00;
        end else begin
            out_valid <= in_valid;
            out_data  <= pbits;
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid))); // R3
    AST_EMPTY_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid == 2'b00) |-> (out_data == 2'b00)); // R3
    AST_SINGLE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid == 2'b01) |-> (out_data[0] == 1'b0)); // R3

endmodule

// File: rtl/idle_lock_descrambler.sv
// Idle-locked self-synchronizing descrambler for a 0/1/2-bit-per-cycle stream.
// Lane 0 handles the older bit (in_data[0], present when in_valid[1] is set).
// Lane 1 handles the newer bit (in_data[1], present when in_valid is nonzero).
// The lanes are chained, so lock can be gained or lost between them.
// Assumes: one clock domain; synchronous active-low reset.
module idle_lock_descrambler
    import idl_pkg::*;
#(
    parameter int LOCK_RUN    = 29,
    parameter int UNLOCK_BITS = 36000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] in_valid,
    input  logic [1:0] in_data,
    output logic [1:0] out_valid,
    output logic [1:0] out_data,
    output logic       out_locked
);

    localparam int LANES = 2;
    localparam int RUN_W = $clog2(LOCK_RUN + 1);
    localparam int TMR_W = $clog2(UNLOCK_BITS + 1);

    lfsr_t            lfsr_c [LANES+1];
    logic [RUN_W-1:0] run_c  [LANES+1];
    logic [TMR_W-1:0] tmr_c  [LANES+1];
    mode_e            mode_c [LANES+1];
    logic [LANES-1:0] lane_en;
    logic [LANES-1:0] pbits;

    // Lane enables, from the count code.
    always_comb begin
        lane_en[0] = in_valid[1];
        lane_en[1] = |in_valid;
    end

    idl_state_reg #(
        .LOCK_RUN(LOCK_RUN), .UNLOCK_BITS(UNLOCK_BITS), .RUN_W(RUN_W), .TMR_W(TMR_W)
    ) u_state (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .lfsr_d(lfsr_c[LANES]), .run_d(run_c[LANES]), .tmr_d(tmr_c[LANES]), .mode_d(mode_c[LANES]),
        .lfsr_q(lfsr_c[0]), .run_q(run_c[0]), .tmr_q(tmr_c[0]), .mode_q(mode_c[0])
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        idl_bit_step #(
            .LOCK_RUN(LOCK_RUN), .UNLOCK_BITS(UNLOCK_BITS), .RUN_W(RUN_W), .TMR_W(TMR_W)
        ) u_step (
            .en(lane_en[g]), .cbit(in_data[g]),
            .lfsr_i(lfsr_c[g]), .run_i(run_c[g]), .tmr_i(tmr_c[g]), .mode_i(mode_c[g]),
            .lfsr_o(lfsr_c[g+1]), .run_o(run_c[g+1]), .tmr_o(tmr_c[g+1]), .mode_o(mode_c[g+1]),
            .pbit_o(pbits[g])
        );
    end

    idl_out_reg u_out (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pbits(pbits),
        .out_valid(out_valid), .out_data(out_data)
    );

    assign out_locked = (mode_c[0] == ST_LOCKED);

endmodule

// File: tb/idle_lock_descrambler_test.sv
module idle_lock_descrambler_test;

    localparam int RUN = 29;
    localparam int LIM = 200;

    // Each entry is {valid[1:0], plain1, plain0}.
    localparam logic [3:0] VEC [0:15] = '{
        4'b1101, 4'b0110, 4'b1000, 4'b0001, 4'b1110, 4'b0100, 4'b1011, 4'b0111,
        4'b0000, 4'b1001, 4'b1111, 4'b0011, 4'b1100, 4'b0101, 4'b0010, 4'b1010
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] in_valid = 2'b00;
    logic [1:0] in_data = 2'b00;
    logic [1:0] out_valid;
    logic [1:0] out_data;
    logic       out_locked;

    int    checks = 0;
    int    errors = 0;
    logic  lk = 1'b0;
    logic [10:0] tx_s = 11'h5A3;

    always #5 clk = ~clk;

    idle_lock_descrambler #(.LOCK_RUN(RUN), .UNLOCK_BITS(LIM)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .out_locked(out_locked)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Far-end scrambler model: one plaintext bit in, one line bit out.
    task automatic tx_bit(input logic p, output logic c);
        logic k;
        k = tx_s[10] ^ tx_s[8];
        c = p ^ k;
        tx_s = {tx_s[9:0], k};
    endtask

    // Drive one cycle, then check the registered result at the next falling edge.
    task automatic drive(input logic [1:0] v, input logic p0, input logic p1);
        logic c0, c1;
        logic [1:0] exp_d;
        c0 = 1'b1;
        c1 = 1'b1;
        if (v[1]) tx_bit(p0, c0);
        if (v != 2'b00) tx_bit(p1, c1);
        in_valid = v;
        in_data  = {c1, c0};
        @(posedge clk);
        @(negedge clk);
        exp_d = v[1] ? {p1, p0} : (v[0] ? {p1, 1'b0} : 2'b00);
        chk(out_valid == v, "R3 valid delay", out_valid, v);
        if (!v[1]) chk(out_data[0] == 1'b0, "R3 empty position zero", out_data[0], 0);
        if (lk) chk(out_data == exp_d, "R4 R2 plaintext", out_data, exp_d);
    endtask

    task automatic idle1(input int n);
        for (int i = 0; i < n; i++) drive(2'b01, 1'b1, 1'b1);
    endtask

    task automatic alt1(input int n);
        for (int i = 0; i < n; i++) drive(2'b01, 1'b0, i[0]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(out_valid == 2'b00, "R1 valid", out_valid, 0);
        chk(out_data == 2'b00, "R1 data", out_data, 0);
        chk(out_locked == 1'b0, "R1 locked", out_locked, 0);
        rst_n = 1'b1;

        // R5: no lock before a full run
        for (int i = 0; i < RUN - 1; i++) begin
            drive(2'b01, 1'b1, 1'b1);
            chk(out_locked == 1'b0, "R5 early lock", out_locked, 0);
        end
        // R6: lock within RUN+11 idle bits
        idle1(12);
        chk(out_locked == 1'b1, "R6 lock acquired", out_locked, 1);
        lk = 1'b1;

        // R2 R3 R4 R9: table of mixed bit counts after lock
        for (int i = 0; i < 16; i++) begin
            drive(VEC[i][3:2], VEC[i][0], VEC[i][1]);
            if (VEC[i][3:2] == 2'b00)
                chk(out_data == 2'b00, "R9 empty cycle ignored", out_data, 0);
        end

        // R8: a full run refreshes the counter on the bit that would expire it
        drive(2'b01, 1'b0, 1'b0);
        idle1(RUN);
        alt1(LIM - RUN);
        idle1(RUN);
        chk(out_locked == 1'b1, "R8 refresh at limit", out_locked, 1);

        // R7: unlock exactly at the limit
        alt1(LIM - 1);
        chk(out_locked == 1'b1, "R7 still locked", out_locked, 1);
        drive(2'b01, 1'b0, 1'b0);
        chk(out_locked == 1'b0, "R7 unlock at limit", out_locked, 0);
        lk = 1'b0;

        // R6 R2: relock with two bits per cycle
        for (int i = 0; i < (RUN + 11) / 2; i++) drive(2'b11, 1'b1, 1'b1);
        chk(out_locked == 1'b1, "R6 two-bit relock", out_locked, 1);
        lk = 1'b1;

        // R8: one bit short of a run does not refresh
        alt1(LIM - RUN);
        idle1(RUN - 1);
        chk(out_locked == 1'b1, "R8 short run locked", out_locked, 1);
        drive(2'b01, 1'b0, 1'b0);
        chk(out_locked == 1'b0, "R8 short run expires", out_locked, 0);
        lk = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule